// File: doc/BRIEF.md
# System Time Counter with Reference Prescaler

This block keeps a 64-bit free-running time value for a multi-core host. The count advances on ticks made from an external reference oscillator by an integer prescaler. The prescaler divides by its 3-bit setting plus one. Counting needs two things at once: software has set the enable bit, and the oscillator-valid input is high. When the oscillator is reported valid with the block enabled, counting begins on that cycle, with no further software action.

Software reaches the block through a small 32-bit register port with write enable, read enable, a byte address and data. Through it, software can:

- start or stop counting;
- store the tick rate in a frequency register that only reports and has no effect on counting;
- set the prescaler;
- read the time as two 32-bit words.

Reading the low word captures the high word in a shadow register. A later high-word read then returns a value that matches that low word, even if a carry into the high half happened in between. The full count is also driven out on a parallel bus for distribution to the cores.

The whole block runs on the reference clock `clk`. Register accesses are synchronous to it.

Top module: `sys_time_counter`

## Requirements
- R1: After a synchronous reset:
  - the count and the divider phase are zero;
  - the enable bit reads 0 at byte address 0x00;
  - the frequency register reads 0 at 0x04;
  - the prescaler reads 7 at 0x08.
- R2: While running, the count rises by one every (P+1) cycles, where P is the prescaler value. With the reset value P=7, the first increment lands on the 8th running cycle after enable.
- R3: Bit 0 at 0x00 is the enable. Writing 0 freezes the count, and writing 1 resumes counting.
- R4: While `osc_valid_i` is low, the count and the divider phase hold. When it returns high, the count advances on that cycle with no register access.
- R5: The register at 0x04 stores all 32 written bits and reads them back. Writing it leaves the counting rate unchanged.
- R6: The prescaler sits at 0x08 in bits 2:0. Bits 31:3 are ignored on write and read as zero.
- R7: Any write to 0x08 clears the divider phase. The next increment then comes a full P+1 running cycles after the write.
- R8: Address 0x0C returns count bits 31:0, and address 0x10 returns bits 63:32. The high word comes from a shadow that is loaded whenever 0x0C is read. Both addresses ignore writes.
- R9: Any address other than 0x00, 0x04, 0x08, 0x0C and 0x10 reads as zero. Writes to such an address change nothing.
- R10: `rd_data_o` is registered: it shows the addressed value as of the clock edge that samples `rd_en_i`, and it holds between reads. `count_o` carries the live 64-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_valid_i | input | 1 | Reference oscillator reported stable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte address of the register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| count_o | output | 64 | Live time count for the cores |

## Verification
Each internal fault shows up at the ports as a time error, and how soon depends on where the fault is:

- A divider phase that is off, or not cleared on a prescaler write, moves the next increment on `count_o` by up to P cycles. It is visible within one divider period.
- Gating that leaks while the oscillator is invalid or the block is disabled changes `count_o` within P+1 cycles.
- A shadow that is not loaded or is read live only shows on the high-word read that follows a low-word read across a carry. For that case the in-RTL property on the shadow load carries the check.
- Decode errors show on the very next read as a wrong or non-zero word.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int ADR_CTRL  = 'h00;
  localparam int ADR_FREQ  = 'h04;
  localparam int ADR_PRESC = 'h08;
  localparam int ADR_CNTLO = 'h0C;
  localparam int ADR_CNTHI = 'h10;
endpackage

// File: rtl/stc_prescaler.sv
module stc_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  assign tick_o = run_i && !load_i && (phase_q == div_i);

  always_ff @(posedge clk) begin
    if (rst)               phase_q <= '0;
    else if (load_i)       phase_q <= '0;
    else if (tick_o)       phase_q <= '0;
    else if (run_i)        phase_q <= phase_q + 1'b1;
  end

  // R7: a prescaler write restarts the phase
  a_r7_phase_restart: assert property (@(posedge clk) disable iff (rst)
    load_i |=> phase_q == '0);
  // R4: phase is frozen while not running
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> $stable(phase_q));
  // R2: phase never passes the divide setting
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
    load_i |=> phase_q <= div_i);
endmodule

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R2: count moves by at most one per cycle, and only on a tick
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r2_no_step: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/stc_regfile.sv
module stc_regfile
  import stc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [2*DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                en_o,
  output logic [DIV_W-1:0]    div_o,
  output logic                div_load_o
);
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  logic [DATA_W-1:0] freq_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_ctrl, hit_freq, hit_presc, hit_lo, hit_hi;

  assign hit_ctrl  = addr_i == ADDR_W'(ADR_CTRL);
  assign hit_freq  = addr_i == ADDR_W'(ADR_FREQ);
  assign hit_presc = addr_i == ADDR_W'(ADR_PRESC);
  assign hit_lo    = addr_i == ADDR_W'(ADR_CNTLO);
  assign hit_hi    = addr_i == ADDR_W'(ADR_CNTHI);

  assign div_load_o = wr_en_i && hit_presc;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      freq_q <= '0;
      div_o  <= DIV_RST;
    end else if (wr_en_i) begin
      if (hit_ctrl)  en_o   <= wr_data_i[0];
      if (hit_freq)  freq_q <= wr_data_i;
      if (hit_presc) div_o  <= wr_data_i[DIV_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)  rd_mux[0]         = en_o;
    if (hit_freq)  rd_mux            = freq_q;
    if (hit_presc) rd_mux[DIV_W-1:0] = div_o;
    if (hit_lo)    rd_mux            = cnt_i[DATA_W-1:0];
    if (hit_hi)    rd_mux            = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      shadow_q  <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= rd_mux;
      if (hit_lo) shadow_q <= cnt_i[2*DATA_W-1:DATA_W];
    end
  end

  // R8: low read captures the high half in the shadow
  a_r8_shadow_load: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && hit_lo) |=> shadow_q == $past(cnt_i[2*DATA_W-1:DATA_W]));
  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !(hit_ctrl || hit_freq || hit_presc || hit_lo || hit_hi))
      |=> rd_data_o == '0);
  // R10: read data holds between reads
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/sys_time_counter.sv
module sys_time_counter #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_valid_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [2*DATA_W-1:0] count_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic             en;
  logic [DIV_W-1:0] div;
  logic             div_load;
  logic             run;
  logic             tick;

  assign run = en && osc_valid_i;

  stc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .cnt_i      (count_o),
    .rd_data_o  (rd_data_o),
    .en_o       (en),
    .div_o      (div),
    .div_load_o (div_load)
  );

  stc_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .load_i (div_load),
    .div_i  (div),
    .tick_o (tick)
  );

  stc_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .cnt_o  (count_o)
  );

  // R4: count is frozen while the oscillator is invalid
  a_r4_osc_hold: assert property (@(posedge clk) disable iff (rst)
    !osc_valid_i |=> $stable(count_o));
  // R3: count is frozen while disabled
  a_r3_en_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count_o));
endmodule

// File: tb/sys_time_counter_tb.sv
module sys_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        osc_valid;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [63:0] count;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  sys_time_counter dut_i (
    .clk(clk), .rst(rst), .osc_valid_i(osc_valid), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .count_o(count)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 count", count, 64'd0);
    reg_rd(5'h00, d); check("R1 ctrl", d, 0);
    reg_rd(5'h04, d); check("R1 freq", d, 0);
    reg_rd(5'h08, d); check("R1 presc", d, 7);
    reg_rd(5'h10, d); check("R8 hi at reset", d, 0);
  endtask

  task automatic t_default_div;
    osc_valid = 1'b1;
    reg_wr(5'h00, 32'h1);
    wait_n(7); check("R2 before 8th cycle", count, 0);
    wait_n(1); check("R2 8th cycle", count, 1);
    wait_n(72); check("R2 div8 rate", count, 10);
  endtask

  task automatic t_enable_stop;
    logic [63:0] c;
    reg_wr(5'h00, 32'h0);
    c = count;
    wait_n(30); check("R3 disabled holds", count, c);
  endtask

  task automatic t_presc_rw;
    logic [31:0] d;
    reg_wr(5'h08, 32'hFFFF_FFF2);
    reg_rd(5'h08, d); check("R6 presc readback", d, 2);
    reg_wr(5'h08, 32'h0);
  endtask

  task automatic t_osc_gate;
    logic [63:0] c;
    reg_wr(5'h00, 32'h1);
    c = count;
    wait_n(5); check("R2 div1 rate", count, c + 5);
    osc_valid = 1'b0;
    c = count;
    wait_n(20); check("R4 osc invalid holds", count, c);
    osc_valid = 1'b1;
    wait_n(3); check("R4 resumes at once", count, c + 3);
  endtask

  task automatic t_freq;
    logic [31:0] d;
    logic [63:0] c;
    reg_wr(5'h04, 32'h1234_5678);
    reg_rd(5'h04, d); check("R5 freq readback", d, 32'h1234_5678);
    c = count;
    wait_n(16); check("R5 rate unchanged", count, c + 16);
  endtask

  task automatic t_restart;
    logic [63:0] c;
    osc_valid = 1'b0;
    reg_wr(5'h08, 32'h3);
    c = count;
    osc_valid = 1'b1;
    wait_n(3); check("R2 div4 early", count, c);
    wait_n(1); check("R2 div4 tick", count, c + 1);
    wait_n(2);
    reg_wr(5'h08, 32'h3);
    check("R7 no tick on write", count, c + 1);
    wait_n(3); check("R7 full period pending", count, c + 1);
    wait_n(1); check("R7 tick after full period", count, c + 2);
  endtask

  task automatic t_split_read;
    logic [31:0] d;
    logic [63:0] c;
    c = count;
    reg_rd(5'h0C, d); check("R8 low word running", d, c[31:0]);
    reg_rd(5'h10, d); check("R8 high from shadow", d, c[63:32]);
    osc_valid = 1'b0;
    c = count;
    reg_wr(5'h0C, 32'hFFFF_0000);
    reg_wr(5'h10, 32'h0000_FFFF);
    reg_rd(5'h0C, d); check("R8 low write ignored", d, c[31:0]);
    reg_rd(5'h10, d); check("R8 high write ignored", d, c[63:32]);
    check("R10 bus matches", count, c);
    wait_n(3); check("R10 rd_data holds", rd_data, c[63:32]);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    reg_wr(5'h14, 32'hDEAD_BEEF);
    reg_wr(5'h1C, 32'h0);
    reg_rd(5'h14, d); check("R9 unmapped 0x14", d, 0);
    reg_rd(5'h1C, d); check("R9 unmapped 0x1C", d, 0);
    reg_rd(5'h00, d); check("R9 ctrl untouched", d, 1);
    reg_rd(5'h04, d); check("R9 freq untouched", d, 32'h1234_5678);
    reg_rd(5'h08, d); check("R9 presc untouched", d, 3);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst = 1'b1; osc_valid = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wr_data = '0;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset;
    t_default_div;
    t_enable_stop;
    t_presc_rw;
    t_osc_gate;
    t_freq;
    t_restart;
    t_split_read;
    t_unmapped;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule